// File: doc/BRIEF.md
# Programmable Lookup Logic Unit

The unit realises an arbitrary mapping from an input word to a 16-bit output word. A host-writable table holds one output word for every input value, so each output bit can be any logic function of the inputs. A rising edge on the input-enable line registers the input word. That word then addresses the table. The ready output goes low on that edge and comes back high once the looked-up word is on the outputs.

The outputs are split into groups of four bits. Each group can be switched into pulse mode. In pulse mode the group shows the looked-up bits for a programmed number of clock cycles and then returns to zero. Groups that are not in pulse mode hold their value until the next lookup starts. A simple host port carries two kinds of write: table entry writes and a configuration write. The configuration write sets the pulse-group mask and the pulse length. The input width equals the table address width and is a parameter. A full-size build uses 16; smaller builds keep simulation cheap.

Top module: `lut_unit`

## Requirements
- R1: After reset, `out_data_o` is all zero and `out_ready_o` is low.
- R2: A lookup starts on a clock edge at which `in_en_i` is high and was low at the previous edge. The lookup captures `in_data_i` as the table address, and `out_ready_o` is low from that edge onward.
- R3: `out_ready_o` rises on the second clock edge after the start edge. At that point the outputs carry the table entry at the captured address. While `out_ready_o` is low, `out_data_o` is all zero.
- R4: Holding `in_en_i` high starts no further lookup. While it stays high, `out_ready_o` and the outputs do not change, even if `in_data_i` changes.
- R5: A host write with `host_we_i`=1 and `host_sel_i`=0 stores `host_wdata_i` into the table entry at `host_addr_i`, provided no lookup is in progress.
- R6: A table write is ignored if it falls on a start edge or on either of the two edges that follow it.
- R7: A host write with `host_sel_i`=1 loads the configuration. Bit g of `host_wdata_i` (g=0..3) enables pulse mode for output group g, which is output bits 4g+3..4g. Bits 7..4 give the pulse length L. This write is accepted at any time and takes effect at the next result. After reset, no group is in pulse mode and L=1.
- R8: A pulse-mode group shows its looked-up bits for exactly max(L,1) cycles after `out_ready_o` rises, and is zero afterwards.
- R9: A group that is not in pulse mode holds its looked-up bits until the next lookup starts. `out_ready_o` stays high after a pulse ends.
- R10: A start edge that arrives while a pulse is running clears the outputs and restarts both the lookup and the pulse timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_en_i | input | 1 | Input enable; its rising edge starts a lookup |
| in_data_i | input | ADDR_W | Input word, used as the table address |
| host_we_i | input | 1 | Host write strobe |
| host_sel_i | input | 1 | Write target: 0 selects the table, 1 selects the configuration |
| host_addr_i | input | ADDR_W | Table entry index |
| host_wdata_i | input | OUT_W | Table entry value or configuration word |
| out_data_o | output | OUT_W | Lookup result |
| out_ready_o | output | 1 | Result valid |

## Verification
The bench builds the unit with ADDR_W=6, which gives a 64-entry table. Every entry can therefore be written and swept, and the bench keeps a full mirror of the table. OUT_W=16 and a four-bit pulse length are kept, so all four groups can be used in any mix of pulse and hold. The extreme lengths 0, 1 and 15 all fall within the tracked window. Directed cases cover three timing hazards: table writes placed on each cycle of the lookup window, a restart placed inside a running pulse, and an enable held high while the input word changes.

// File: rtl/lut_pkg.sv
package lut_pkg;
  typedef enum logic {
    HOST_TABLE = 1'b0,
    HOST_CFG   = 1'b1
  } host_tgt_e;

  // zero length behaves as one cycle
  function automatic logic [3:0] len_floor4(input logic [3:0] len);
    return (len == 4'd0) ? 4'd1 : len;
  endfunction
endpackage

// File: rtl/lut_capture.sv
module lut_capture #(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              start_o,
  output logic              busy_o,
  output logic              load_o
);
  logic en_q, s1_q, s2_q;
  logic [ADDR_W-1:0] addr_q;

  assign start_o = en_i & ~en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q <= en_i;
      s1_q <= start_o;
      s2_q <= s1_q & ~start_o;
      if (start_o) addr_q <= data_i;
    end
  end

  assign addr_o = addr_q;
  assign busy_o = s1_q | s2_q;
  assign load_o = s2_q;
endmodule

// File: rtl/lut_mem.sv
module lut_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/lut_out.sv
module lut_out #(
  parameter int OUT_W = 16,
  parameter int GRP_W = 4,
  parameter int CNT_W = 4,
  localparam int NGRP = OUT_W / GRP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [OUT_W-1:0] rdata_i,
  input  logic [NGRP-1:0]  pmask_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [OUT_W-1:0] data_o,
  output logic             ready_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [NGRP-1:0]  pmask_q;
  logic             ready_q;
  logic             expire;
  logic [CNT_W-1:0] len_eff;

  assign len_eff = (len_i == '0) ? CNT_W'(1) : len_i;
  assign expire  = (cnt_q == CNT_W'(1)) & ~clr_i & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pmask_q <= '0;
      ready_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q   <= '0;
      ready_q <= 1'b0;
    end else if (load_i) begin
      cnt_q   <= len_eff;
      pmask_q <= pmask_i;
      ready_q <= 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GRP_W-1:0] grp_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  grp_q <= '0;
      else if (clr_i)               grp_q <= '0;
      else if (load_i)              grp_q <= rdata_i[g*GRP_W +: GRP_W];
      else if (expire & pmask_q[g]) grp_q <= '0;
    end
    assign data_o[g*GRP_W +: GRP_W] = grp_q;
  end

  assign ready_o = ready_q;
endmodule

// File: rtl/lut_unit.sv
module lut_unit #(
  parameter int ADDR_W = 10,
  parameter int OUT_W  = 16,
  parameter int GRP_W  = 4,
  parameter int CNT_W  = 4,
  localparam int NGRP  = OUT_W / GRP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_en_i,
  input  logic [ADDR_W-1:0] in_data_i,
  input  logic              host_we_i,
  input  logic              host_sel_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [OUT_W-1:0]  host_wdata_i,
  output logic [OUT_W-1:0]  out_data_o,
  output logic              out_ready_o
);
  import lut_pkg::*;

  logic [ADDR_W-1:0] addr;
  logic              start, busy, load;
  logic [OUT_W-1:0]  rdata;
  logic              tbl_we;
  logic [NGRP-1:0]   pmask_q;
  logic [CNT_W-1:0]  len_q;

  lut_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (in_en_i),
    .data_i (in_data_i),
    .addr_o (addr),
    .start_o(start),
    .busy_o (busy),
    .load_o (load)
  );

  // table is locked from the start edge until the result is loaded
  assign tbl_we = host_we_i & (host_sel_i == HOST_TABLE) & ~start & ~busy;

  lut_mem #(.ADDR_W(ADDR_W), .DATA_W(OUT_W)) u_mem (
    .clk_i  (clk_i),
    .we_i   (tbl_we),
    .waddr_i(host_addr_i),
    .wdata_i(host_wdata_i),
    .raddr_i(addr),
    .rdata_o(rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pmask_q <= '0;
      len_q   <= CNT_W'(1);
    end else if (host_we_i && host_sel_i == HOST_CFG) begin
      pmask_q <= host_wdata_i[NGRP-1:0];
      len_q   <= host_wdata_i[NGRP +: CNT_W];
    end
  end

  lut_out #(.OUT_W(OUT_W), .GRP_W(GRP_W), .CNT_W(CNT_W)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .load_i (load),
    .rdata_i(rdata),
    .pmask_i(pmask_q),
    .len_i  (len_q),
    .data_o (out_data_o),
    .ready_o(out_ready_o)
  );
endmodule

// File: rtl/lut_unit_chk.sv
module lut_unit_chk #(
  parameter int OUT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_en_i,
  input logic [OUT_W-1:0] out_data_o,
  input logic             out_ready_o
);
  logic en_prev, e1, e2, e3;
  logic edge_c;

  assign edge_c = in_en_i & ~en_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_prev <= 1'b0;
      e1 <= 1'b0;
      e2 <= 1'b0;
      e3 <= 1'b0;
    end else begin
      en_prev <= in_en_i;
      e1 <= edge_c;
      e2 <= e1;
      e3 <= e2;
    end
  end

  p_ready_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_c |=> !out_ready_o);

  p_clear_on_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_c |=> out_data_o == '0);

  p_ready_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_ready_o) |-> e3);

  p_zero_not_ready_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_ready_o |-> out_data_o == '0);

  p_no_retrigger_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_ready_o && in_en_i && en_prev) |=> out_ready_o);
endmodule

bind lut_unit lut_unit_chk #(.OUT_W(OUT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .in_en_i    (in_en_i),
  .out_data_o (out_data_o),
  .out_ready_o(out_ready_o)
);

// File: tb/tb_lut_unit.sv
`timescale 1ns/1ps
module tb_lut_unit;
  localparam int AW = 6;
  localparam int OW = 16;
  localparam int GW = 4;
  localparam int CW = 4;
  localparam int NG = OW / GW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_en = 1'b0;
  logic [AW-1:0] in_data = '0;
  logic host_we = 1'b0;
  logic host_sel = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [OW-1:0] host_wdata = '0;
  logic [OW-1:0] out_data;
  logic out_ready;

  always #2.5 clk = ~clk;

  lut_unit #(.ADDR_W(AW), .OUT_W(OW), .GRP_W(GW), .CNT_W(CW)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_en_i(in_en), .in_data_i(in_data),
    .host_we_i(host_we), .host_sel_i(host_sel), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .out_data_o(out_data), .out_ready_o(out_ready)
  );

  logic [OW-1:0] model [DEPTH];
  logic [NG-1:0] m_mask = '0;
  int m_len = 1;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input string rq, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] expv(input logic [OW-1:0] v, input logic [NG-1:0] mk,
                                         input int c, input int len);
    logic [OW-1:0] r = v;
    int le = (len == 0) ? 1 : len;
    for (int g = 0; g < NG; g++)
      if (mk[g] && c >= le) r[g*GW +: GW] = '0;
    return r;
  endfunction

  task automatic host_tbl(input logic [AW-1:0] a, input logic [OW-1:0] d);
    @(negedge clk);
    host_we = 1; host_sel = 0; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 0;
    model[a] = d;
  endtask

  task automatic host_cfg(input logic [NG-1:0] mk, input int len);
    @(negedge clk);
    host_we = 1; host_sel = 1;
    host_wdata = '0;
    host_wdata[NG-1:0] = mk;
    host_wdata[NG +: CW] = CW'(len);
    @(negedge clk);
    host_we = 0;
    m_mask = mk; m_len = len;
  endtask

  // returns at the first sample with ready high (pulse cycle 0)
  task automatic lookup(input logic [AW-1:0] a, input string rq);
    @(negedge clk);
    in_en = 1; in_data = a;
    @(negedge clk);
    in_en = 0;
    chk({rq, " R2 ready low after start"}, OW'(out_ready), OW'(0));
    chk({rq, " R3 zero while busy"}, out_data, '0);
    @(negedge clk);
    chk("R3 ready still low", OW'(out_ready), OW'(0));
    @(negedge clk);
    chk({rq, " R3 ready high"}, OW'(out_ready), OW'(1));
    chk({rq, " R3 result"}, out_data, expv(model[a], m_mask, 0, m_len));
  endtask

  task automatic track(input logic [AW-1:0] a, input int n);
    for (int c = 1; c <= n; c++) begin
      @(negedge clk);
      chk("R8 R9 pulse/hold", out_data, expv(model[a], m_mask, c, m_len));
      chk("R9 ready stays high", OW'(out_ready), OW'(1));
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset data", out_data, '0);
    chk("R1 reset ready", OW'(out_ready), OW'(0));
    rst_ni = 1;

    for (int a = 0; a < DEPTH; a++) host_tbl(AW'(a), OW'($urandom()));

    // R5 sweep of the whole table, hold mode, reset configuration
    for (int a = 0; a < DEPTH; a++) lookup(AW'(a), "R5 sweep");

    // R6 writes on the start edge and the two edges after it are dropped
    host_tbl(6'd5, 16'hA5A5);
    @(negedge clk);
    in_en = 1; in_data = 6'd5;
    host_we = 1; host_sel = 0; host_addr = 6'd5; host_wdata = 16'h1111;
    @(negedge clk);
    in_en = 0; host_wdata = 16'h2222;
    @(negedge clk);
    host_wdata = 16'h3333;
    @(negedge clk);
    host_we = 0;
    chk("R6 result during locked writes", out_data, 16'hA5A5);
    lookup(6'd5, "R6 table unchanged");
    host_tbl(6'd5, 16'h5A3C);
    lookup(6'd5, "R5 write accepted when idle");

    // R7 R8 all groups pulse, lengths 0, 1, 15
    host_cfg(4'hF, 0);  lookup(6'd9, "R8 len0");  track(6'd9, 4);
    host_cfg(4'hF, 1);  lookup(6'd9, "R8 len1");  track(6'd9, 4);
    host_cfg(4'hF, 15); lookup(6'd9, "R8 len15"); track(6'd9, 17);
    host_cfg(4'b0101, 3); lookup(6'd12, "R7 R9 mixed"); track(6'd12, 6);

    // R10 restart inside a pulse
    host_cfg(4'hF, 8);
    lookup(6'd20, "R10 first");
    track(6'd20, 2);
    lookup(6'd21, "R10 restart");
    track(6'd21, 10);

    // R4 enable held high, input changes
    host_cfg(4'h0, 1);
    @(negedge clk);
    in_en = 1; in_data = 6'd30;
    repeat (3) @(negedge clk);
    chk("R4 first result", out_data, model[30]);
    in_data = 6'd31;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R4 no retrigger data", out_data, model[30]);
      chk("R4 no retrigger ready", OW'(out_ready), OW'(1));
    end
    in_en = 0;

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [AW-1:0] a = AW'($urandom());
      host_cfg(NG'($urandom()), int'($urandom_range(0, 15)));
      if (it % 4 == 0) host_tbl(AW'($urandom()), OW'($urandom()));
      lookup(a, "R3 random");
      track(a, 16);
    end

    finish_up();
  end
endmodule